// File: doc/BRIEF.md
# Multi-Format Pixel Unpacker

This block sits between a framebuffer fetch path and a video encoder. It takes 32-bit framebuffer words over a valid/ready handshake. On every clock, which is one pixel slot, it delivers one registered 24-bit RGB pixel. The stored pixel format can be selected at run time. It can be one of two 16-bit layouts, a packed 24-bit layout in which pixels cross word boundaries, or a 32-bit layout with one pixel per word.

A timing generator outside the block tells it, slot by slot, whether the current position is in the active window, in the border region, or in neither. Window slots take the next pixel from the byte stream. Border slots show a programmable border colour. All other slots are black. Clearing the display enable blanks the whole output to black and freezes the byte stream, so the picture resumes at the same pixel when the enable is set again.

Top module: `pix_unpack`

## Requirements
- R1: `fmt` selects the stored layout. Code 0 is 15-bit colour in 16 bits, 1 is 16-bit colour in 16 bits, 2 is packed 24-bit colour using 3 bytes per pixel, and 3 is 24-bit colour in a 32-bit word using 4 bytes per pixel.
- R2: In the 16-bit codes each word yields two pixels, taking the low halfword first. Across all codes, bytes are consumed from the least significant byte of each word upward.
- R3: In code 0 a halfword holds red in bits 14:10, green in 9:5 and blue in 4:0, and bit 15 is ignored. Each 5-bit channel is widened to 8 bits by appending its top 3 bits.
- R4: In code 1 a halfword holds red in 15:11, green in 10:5 and blue in 4:0. 5-bit channels get their top 3 bits appended, and the 6-bit channel gets its top 2 bits appended.
- R5: In code 2 three consecutive words carry four pixels. Each pixel is three successive bytes in the order blue, green, red, and a pixel may straddle two words.
- R6: In code 3 a word gives blue in bits 7:0, green in 15:8 and red in 23:16, and bits 31:24 are ignored.
- R7: While `disp_en` is 0 every slot outputs black with `pix_valid` = 1, and no stream bytes are consumed. Once enabled again, output continues with the next unconsumed pixel.
- R8: With `disp_en` = 1, a slot with `in_border` = 1 and `in_window` = 0 outputs `border_rgb`, which holds blue in 7:0, green in 15:8 and red in 23:16. The window takes priority over the border.
- R9: With `disp_en` = 1, a slot that is in neither the window nor the border outputs black with `pix_valid` = 1.
- R10: `word_ready` is 1 exactly when fewer bytes are buffered than one pixel of the current format needs. A word is taken on a clock where `word_valid` and `word_ready` are both 1.
- R11: A window slot with display enabled, when the buffered bytes plus any word taken in that same cycle are fewer than one pixel, outputs black with `pix_valid` = 0 and consumes nothing.
- R12: The outputs for a slot appear one clock after the slot's inputs. Reset is synchronous and active high, and clears the buffer and both outputs to 0, so `word_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| word_data | input | 32 | Framebuffer word |
| word_valid | input | 1 | Word available |
| word_ready | output | 1 | Block accepts a word this cycle |
| fmt | input | 2 | Pixel format select |
| disp_en | input | 1 | Display enable |
| in_window | input | 1 | Current slot is in the active window |
| in_border | input | 1 | Current slot is in the border region |
| border_rgb | input | 24 | Border colour |
| pix_rgb | output | 24 | Registered pixel, red 23:16, green 15:8, blue 7:0 |
| pix_valid | output | 1 | Pixel carries meaningful data (0 on underrun) |

## Verification
A wrong byte count or a wrong alignment in the carry buffer shows up at once. The next window pixel comes out with shifted or mixed channels, and `word_ready` changes in a different cycle from the byte-level reference. Both are compared on every clock, so a fault is reported within one slot of the cycle that first exposes it. Format changes in the middle of the stream, blanking windows and stalls in the word stream are all mixed in. Leftover bytes therefore have to survive each of these events, and the later pixels expose them if they do not.

// File: rtl/pix_pkg.sv
package pix_pkg;
  typedef enum logic [1:0] {
    FMT_RGB555   = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGB888P  = 2'd2,
    FMT_XRGB8888 = 2'd3
  } pix_fmt_e;

  // bytes one pixel occupies in the stream
  function automatic logic [2:0] fmt_bytes(input pix_fmt_e f);
    case (f)
      FMT_RGB555, FMT_RGB565: fmt_bytes = 3'd2;
      FMT_RGB888P:            fmt_bytes = 3'd3;
      default:                fmt_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pix_byte_buf.sv
module pix_byte_buf
  import pix_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pix_fmt_e          fmt,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pop_req,
  output logic              avail,
  output logic [31:0]       head
);
  localparam int BUF_W  = BUF_BYTES * 8;
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int WORD_B = WORD_W / 8;

  logic [BUF_W-1:0] store_q, merged, store_d;
  logic [CNT_W-1:0] cnt_q, merged_cnt, cnt_d, need;
  logic             take, pop;

  assign need     = CNT_W'(fmt_bytes(fmt));
  assign in_ready = (cnt_q < need);
  assign take     = in_valid && in_ready;

  always_comb begin
    merged     = store_q;
    merged_cnt = cnt_q;
    if (take) begin
      merged     = store_q | ({{(BUF_W-WORD_W){1'b0}}, in_data} << {cnt_q, 3'b000});
      merged_cnt = cnt_q + CNT_W'(WORD_B);
    end
  end

  assign avail = (merged_cnt >= need);
  assign pop   = pop_req && avail;
  assign head  = merged[31:0];

  always_comb begin
    store_d = merged;
    cnt_d   = merged_cnt;
    if (pop) begin
      store_d = merged >> {need, 3'b000};
      cnt_d   = merged_cnt - need;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      cnt_q   <= '0;
    end else begin
      store_q <= store_d;
      cnt_q   <= cnt_d;
    end
  end

  // a full pixel never waits together with a fresh word
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(BUF_BYTES - 1));

  assert_take_grows_R10: assert property (@(posedge clk) disable iff (rst)
    (take && !pop_req) |=> (cnt_q == $past(cnt_q) + CNT_W'(WORD_B)));
endmodule

// File: rtl/pix_decode.sv
module pix_decode
  import pix_pkg::*;
(
  input  pix_fmt_e    fmt,
  input  logic [31:0] head,
  output logic [23:0] rgb
);
  logic [15:0] hw;
  logic [4:0]  r5, b5, g5;
  logic [5:0]  g6;

  assign hw = head[15:0];

  always_comb begin
    r5 = '0; g5 = '0; g6 = '0; b5 = hw[4:0];
    case (fmt)
      FMT_RGB555: begin
        r5  = hw[14:10];
        g5  = hw[9:5];
        rgb = {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2]};
      end
      FMT_RGB565: begin
        r5  = hw[15:11];
        g6  = hw[10:5];
        rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      end
      default: rgb = head[23:0];
    endcase
  end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_en,
  input  logic             in_window,
  input  logic             in_border,
  input  logic [RGB_W-1:0] border_rgb,
  input  logic             pix_ok,
  input  logic [RGB_W-1:0] pix_in,
  output logic [RGB_W-1:0] pix_rgb,
  output logic             pix_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_rgb   <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= 1'b1;
      pix_rgb   <= '0;
      if (disp_en) begin
        if (in_window) begin
          pix_valid <= pix_ok;
          if (pix_ok) pix_rgb <= pix_in;
        end else if (in_border) begin
          pix_rgb <= border_rgb;
        end
      end
    end
  end

  assert_blank_black_R7: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> (pix_rgb == '0) && pix_valid);

  assert_border_colour_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !in_window && in_border) |=> (pix_rgb == $past(border_rgb)) && pix_valid);

  assert_outside_black_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !in_window && !in_border) |=> (pix_rgb == '0) && pix_valid);

  assert_underrun_R11: assert property (@(posedge clk) disable iff (rst)
    (disp_en && in_window && !pix_ok) |=> !pix_valid && (pix_rgb == '0));
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 8,
  parameter int RGB_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [1:0]        fmt,
  input  logic              disp_en,
  input  logic              in_window,
  input  logic              in_border,
  input  logic [RGB_W-1:0]  border_rgb,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pix_valid
);
  pix_fmt_e    fmt_e;
  logic        avail;
  logic [31:0] head;
  logic [23:0] dec_rgb;

  assign fmt_e = pix_fmt_e'(fmt);

  pix_byte_buf #(.WORD_W(WORD_W), .BUF_BYTES(BUF_BYTES)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .fmt      (fmt_e),
    .in_data  (word_data),
    .in_valid (word_valid),
    .in_ready (word_ready),
    .pop_req  (disp_en && in_window),
    .avail    (avail),
    .head     (head)
  );

  pix_decode u_dec (
    .fmt  (fmt_e),
    .head (head),
    .rgb  (dec_rgb)
  );

  pix_out_stage #(.RGB_W(RGB_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .disp_en    (disp_en),
    .in_window  (in_window),
    .in_border  (in_border),
    .border_rgb (border_rgb),
    .pix_ok     (avail),
    .pix_in     (RGB_W'(dec_rgb)),
    .pix_rgb    (pix_rgb),
    .pix_valid  (pix_valid)
  );
endmodule

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [1:0]  fmt = 2'd1;
  logic        disp_en = 1'b0;
  logic        in_window = 1'b0;
  logic        in_border = 1'b0;
  logic [23:0] border_rgb = '0;
  logic [23:0] pix_rgb;
  logic        pix_valid;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pix_unpack u_dut (
    .clk(clk), .rst(rst), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .fmt(fmt), .disp_en(disp_en),
    .in_window(in_window), .in_border(in_border), .border_rgb(border_rgb),
    .pix_rgb(pix_rgb), .pix_valid(pix_valid)
  );

  int q[$];
  int widx = 0;
  logic [23:0] exp_rgb;
  logic        exp_valid;
  string       exp_tag;

  function automatic logic [31:0] gen_word(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  function automatic int need_bytes(input logic [1:0] f);
    return (f < 2) ? 2 : (f == 2) ? 3 : 4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: compute the next pixel from the byte queue
  task automatic model_slot();
    int n, h, r, g, b;
    n = need_bytes(fmt);
    exp_valid = 1'b1;
    exp_rgb   = '0;
    if (!disp_en) exp_tag = "R7";
    else if (in_window) begin
      if (q.size() < n) begin
        exp_valid = 1'b0;
        exp_tag = "R11";
      end else begin
        h = q[0] | (q[1] << 8);
        case (fmt)
          2'd0: begin
            r = (h >> 10) & 31; g = (h >> 5) & 31; b = h & 31;
            r = (r << 3) | (r >> 2); g = (g << 3) | (g >> 2); b = (b << 3) | (b >> 2);
            exp_tag = "R2/R3";
          end
          2'd1: begin
            r = (h >> 11) & 31; g = (h >> 5) & 63; b = h & 31;
            r = (r << 3) | (r >> 2); g = (g << 2) | (g >> 4); b = (b << 3) | (b >> 2);
            exp_tag = "R2/R4";
          end
          2'd2: begin b = q[0]; g = q[1]; r = q[2]; exp_tag = "R5"; end
          default: begin b = q[0]; g = q[1]; r = q[2]; exp_tag = "R6"; end
        endcase
        exp_rgb = 24'((r << 16) | (g << 8) | b);
        for (int k = 0; k < n; k++) void'(q.pop_front());
      end
    end else if (in_border) begin
      exp_rgb = border_rgb;
      exp_tag = "R8";
    end else exp_tag = "R9";
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [1:0] fmts [6] = '{2'd1, 2'd0, 2'd2, 2'd3, 2'd2, 2'd0};
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset pix_rgb", 32'(pix_rgb), 32'h0);
    check("R12 reset pix_valid", 32'(pix_valid), 32'h0);
    check("R12 reset word_ready", 32'(word_ready), 32'h1);
    rst = 1'b0;
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 250; c++) begin
        if (p != 0 || c != 0) begin
          check({exp_tag, " pix_rgb"}, 32'(pix_rgb), 32'(exp_rgb));
          check({exp_tag, " pix_valid"}, 32'(pix_valid), 32'(exp_valid));
        end
        // R1: format code drives the layout
        fmt        = fmts[p];
        disp_en    = !(c >= 100 && c <= 112);
        in_window  = (c % 20) < 14;
        in_border  = ((c % 20) < 17) && ((c % 20) > 5);
        border_rgb = 24'(c * 32'h00010307 ^ 32'h00A55A3C);
        word_valid = ((c % 9) != 4) && !(c % 50 >= 30 && c % 50 <= 34);
        word_data  = gen_word(widx);
        #1;
        check("R10 word_ready", 32'(word_ready), 32'(q.size() < need_bytes(fmt)));
        if (word_valid && (q.size() < need_bytes(fmt))) begin
          for (int k = 0; k < 4; k++) q.push_back(int'((word_data >> (8 * k)) & 32'hFF));
          widx++;
        end
        model_slot();
        @(negedge clk);
      end
    end
    check({exp_tag, " pix_rgb"}, 32'(pix_rgb), 32'(exp_rgb));
    check({exp_tag, " pix_valid"}, 32'(pix_valid), 32'(exp_valid));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule